// File: doc/BRIEF.md
# Program Status Register Unit

This unit keeps the processor's live status word and a saved copy of it for each privileged exception mode. The live word carries four condition flags, two interrupt-disable bits, an execution-state bit and a five-bit mode field. Software reaches these words through register-transfer requests. A read returns either the live word or the saved word of the current mode. A write targets one of them and replaces either the whole word or only the flag nibble. A separate immediate form also writes only the flags.

Two further paths change the live word outside software writes. On exception entry, the exception controller supplies a new live word. The unit then stores the old live word into the saved slot of the mode being entered. On exception return, the unit restores the live word from the saved slot of the current mode. The unit filters every write by privilege: code running in user mode can change only the flags. The reserved bits never change.

Top module: `psr_unit`

## Requirements
- R1: Reset sets the live word to 0x000000D3 (supervisor mode, both interrupt-disable bits set, flags clear) and clears every saved word.
- R2: The layout is fixed: flags in bits 31:28, IRQ disable in bit 7, FIQ disable in bit 6, state bit in bit 5, mode in bits 4:0. Bits 27:8 are reserved and keep their value (zero) across every kind of write, including exception entry.
- R3: In a privileged mode, a whole-word write (`wr_kind`=0) to the live word updates the flags, I, F, T and mode bits.
- R4: In user mode (mode 5'b10000), a whole-word write to the live word changes only bits 31:28. Bits 7:0 keep their value, so the mode cannot change.
- R5: A flag-field write (`wr_kind`=1) updates only bits 31:28 of its target, in any mode.
- R6: An immediate write (`wr_kind`=2) copies bits 31:28 of its 32-bit operand into the flags and leaves every other bit alone.
- R7: `wr_kind`=3 has no effect, and in a cycle with no request the live word holds.
- R8: With `rd_sel_saved`=0, `rd_data` shows the live word. With `rd_sel_saved`=1, it shows the saved word of the current mode. The modes that have a saved slot are FIQ 5'b10001, IRQ 5'b10010, SVC 5'b10011, ABT 5'b10111 and UND 5'b11011. In user (5'b10000) and system (5'b11111) mode, a saved read returns zero.
- R9: A write with `wr_saved`=1 goes to the current mode's saved word. It is ignored in user and system mode.
- R10: On exception entry, the live word takes the flag and control bits of `exc_psr`. The old live word is stored in the saved slot of the mode given in `exc_psr[4:0]`. No slot is written if that mode has none.
- R11: On exception return, the live word is loaded from the current mode's saved word. In user or system mode the request is ignored.
- R12: When requests arrive in the same cycle, exception entry wins over exception return, and exception return wins over a software write. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel_saved | input | 1 | Read select: 0 live word, 1 saved word of current mode |
| rd_data | output | 32 | Read result |
| cur_psr | output | 32 | Live status word |
| wr_en | input | 1 | Software write request |
| wr_saved | input | 1 | Write target: 0 live word, 1 saved word |
| wr_kind | input | 2 | 0 whole word, 1 flag field, 2 immediate flags, 3 none |
| wr_data | input | 32 | Write operand or immediate |
| ret_en | input | 1 | Exception-return request |
| exc_en | input | 1 | Exception-entry request |
| exc_psr | input | 32 | New live word on exception entry |

## Verification
The bench walks the unit through several situations: a user-mode whole-word write, collisions between entry, return and software writes, returns issued from modes that have no saved slot, and an exception entry whose operand has the reserved bits set. A filter that lets user code through would change the mode field. Wrong arbitration would leave the software operand in the live word instead of the entry or restored value. Faulty slot selection would show a saved word under the wrong mode. A mid-run reset checks that saved words holding data return to zero.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W     = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_SAVED = 5;
  localparam int IDX_W     = (NUM_SAVED > 1) ? $clog2(NUM_SAVED) : 1;

  localparam logic [PSR_W-1:0] FLAG_MASK = 32'hF000_0000;
  localparam logic [PSR_W-1:0] CTRL_MASK = 32'h0000_00FF;
  localparam logic [PSR_W-1:0] DEF_MASK  = FLAG_MASK | CTRL_MASK;
  localparam logic [PSR_W-1:0] RESET_PSR = 32'h0000_00D3;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  localparam logic [1:0] WK_WORD  = 2'd0;
  localparam logic [1:0] WK_FLAGS = 2'd1;
  localparam logic [1:0] WK_IMM   = 2'd2;

  // Bits of old outside mask survive; bits inside come from upd.
  function automatic logic [PSR_W-1:0] psr_merge(input logic [PSR_W-1:0] old,
                                                 input logic [PSR_W-1:0] upd,
                                                 input logic [PSR_W-1:0] mask);
    return (old & ~mask) | (upd & mask);
  endfunction

  // Which bits a software write may touch.
  function automatic logic [PSR_W-1:0] psr_wr_mask(input logic [1:0] kind,
                                                   input logic priv);
    logic [PSR_W-1:0] m;
    case (kind)
      WK_WORD:  m = priv ? DEF_MASK : FLAG_MASK;
      WK_FLAGS: m = FLAG_MASK;
      WK_IMM:   m = FLAG_MASK;
      default:  m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              banked,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    banked = 1'b1;
    idx    = '0;
    case (mode)
      MODE_FIQ: idx = IDX_W'(0);
      MODE_IRQ: idx = IDX_W'(1);
      MODE_SVC: idx = IDX_W'(2);
      MODE_ABT: idx = IDX_W'(3);
      MODE_UND: idx = IDX_W'(4);
      default:  banked = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
#(
  parameter int N = NUM_SAVED,
  localparam int IW = (N > 1) ? $clog2(N) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [PSR_W-1:0] wr_word,
  input  logic [IW-1:0]    rd_idx,
  output logic [PSR_W-1:0] rd_word
);
  logic [PSR_W-1:0] slot_q [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && (wr_idx == IW'(g)))
        slot_q[g] <= psr_merge(slot_q[g], wr_word, DEF_MASK);
    end
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < N; i++)
      if (rd_idx == IW'(i)) rd_word = slot_q[i];
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_sel_saved,
  output logic [PSR_W-1:0] rd_data,
  output logic [PSR_W-1:0] cur_psr,
  input  logic             wr_en,
  input  logic             wr_saved,
  input  logic [1:0]       wr_kind,
  input  logic [PSR_W-1:0] wr_data,
  input  logic             ret_en,
  input  logic             exc_en,
  input  logic [PSR_W-1:0] exc_psr
);
  logic [PSR_W-1:0] cur_q, cur_d;
  logic             cur_banked, exc_banked, cur_priv;
  logic [IDX_W-1:0] cur_idx, exc_idx;
  logic [PSR_W-1:0] bank_rd, saved_cur;
  logic             exc_take, ret_take, sw_cur_take, sw_sav_take;
  logic             bank_we;
  logic [IDX_W-1:0] bank_widx;
  logic [PSR_W-1:0] bank_wword;

  psr_mode_decode u_cur_dec (.mode(cur_q[MODE_W-1:0]),   .banked(cur_banked), .idx(cur_idx));
  psr_mode_decode u_exc_dec (.mode(exc_psr[MODE_W-1:0]), .banked(exc_banked), .idx(exc_idx));

  assign cur_priv  = (cur_q[MODE_W-1:0] != MODE_USR);
  assign saved_cur = cur_banked ? bank_rd : '0;

  // Arbitration events, exposed for the checker.
  assign exc_take    = exc_en;
  assign ret_take    = ret_en & ~exc_en & cur_banked;
  assign sw_cur_take = wr_en & ~exc_en & ~ret_en & ~wr_saved;
  assign sw_sav_take = wr_en & ~exc_en & ~ret_en &  wr_saved & cur_banked;

  always_comb begin
    cur_d = cur_q;
    if (exc_take)
      cur_d = psr_merge(cur_q, exc_psr, DEF_MASK);
    else if (ret_take)
      cur_d = psr_merge(cur_q, saved_cur, DEF_MASK);
    else if (sw_cur_take)
      cur_d = psr_merge(cur_q, wr_data, psr_wr_mask(wr_kind, cur_priv));
  end

  always_comb begin
    bank_we    = 1'b0;
    bank_widx  = cur_idx;
    bank_wword = cur_q;
    if (exc_take) begin
      bank_we    = exc_banked;
      bank_widx  = exc_idx;
      bank_wword = cur_q;
    end else if (sw_sav_take) begin
      bank_we    = 1'b1;
      bank_widx  = cur_idx;
      bank_wword = psr_merge(saved_cur, wr_data, psr_wr_mask(wr_kind, 1'b1));
    end
  end

  psr_saved_bank #(.N(NUM_SAVED)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bank_we), .wr_idx(bank_widx), .wr_word(bank_wword),
    .rd_idx(cur_idx), .rd_word(bank_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= RESET_PSR;
    else        cur_q <= cur_d;
  end

  assign cur_psr = cur_q;
  assign rd_data = rd_sel_saved ? saved_cur : cur_q;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk
  import psr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_sel_saved,
  input logic [PSR_W-1:0] rd_data,
  input logic [PSR_W-1:0] cur_psr,
  input logic             wr_en,
  input logic             ret_en,
  input logic             exc_en,
  input logic [PSR_W-1:0] exc_psr,
  input logic [PSR_W-1:0] saved_cur,
  input logic             ret_take,
  input logic             sw_cur_take,
  input logic             cur_priv
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_psr[27:8] == '0);

  // R4
  user_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_cur_take && !cur_priv) |=> (cur_psr[7:0] == $past(cur_psr[7:0])));

  // R10
  exc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_en |=> ((cur_psr[31:28] == $past(exc_psr[31:28])) &&
                (cur_psr[7:0]   == $past(exc_psr[7:0]))));

  // R11
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_take |=> (cur_psr == $past(saved_cur)));

  // R8
  saved_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_saved && ((cur_psr[4:0] == MODE_USR) || (cur_psr[4:0] == MODE_SYS)))
      |-> (rd_data == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en && !ret_en && !wr_en) |=> $stable(cur_psr));
endmodule

bind psr_unit psr_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel_saved(rd_sel_saved), .rd_data(rd_data),
  .cur_psr(cur_psr), .wr_en(wr_en), .ret_en(ret_en), .exc_en(exc_en),
  .exc_psr(exc_psr), .saved_cur(saved_cur), .ret_take(ret_take),
  .sw_cur_take(sw_cur_take), .cur_priv(cur_priv)
);

// File: tb/psr_unit_tb.sv
module psr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_sel_saved = 1'b0;
  logic [31:0] rd_data, cur_psr;
  logic        wr_en = 1'b0, wr_saved = 1'b0, ret_en = 1'b0, exc_en = 1'b0;
  logic [1:0]  wr_kind = 2'd0;
  logic [31:0] wr_data = '0, exc_psr = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  psr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .rd_sel_saved(rd_sel_saved), .rd_data(rd_data),
    .cur_psr(cur_psr), .wr_en(wr_en), .wr_saved(wr_saved), .wr_kind(wr_kind),
    .wr_data(wr_data), .ret_en(ret_en), .exc_en(exc_en), .exc_psr(exc_psr)
  );

  // {req[3:0], ctrl{exc,ret,wr,wsav,kind[1:0]}, wr_data, exc_psr, exp_live, exp_saved}
  localparam int NV = 19;
  localparam logic [137:0] VEC [NV] = '{
    {4'd3,  6'b001000, 32'h5FFFFF92, 32'h0,        32'h50000092, 32'h00000000}, // R3 to IRQ
    {4'd9,  6'b001100, 32'hC12345F3, 32'h0,        32'h50000092, 32'hC00000F3}, // R9 saved word
    {4'd5,  6'b001001, 32'h3FFFFFFF, 32'h0,        32'h30000092, 32'hC00000F3}, // R5 flags
    {4'd6,  6'b001010, 32'h900000FF, 32'h0,        32'h90000092, 32'hC00000F3}, // R6 immediate
    {4'd7,  6'b001011, 32'hFFFFFFFF, 32'h0,        32'h90000092, 32'hC00000F3}, // R7 no-op kind
    {4'd5,  6'b001101, 32'h1FFFFFFF, 32'h0,        32'h90000092, 32'h100000F3}, // R5 saved flags
    {4'd11, 6'b010000, 32'h0,        32'h0,        32'h100000F3, 32'h00000000}, // R11 return
    {4'd10, 6'b100000, 32'h0,        32'h000000DB, 32'h000000DB, 32'h100000F3}, // R10 enter UND
    {4'd12, 6'b111000, 32'hFFFFFFFF, 32'h000000D7, 32'h000000D7, 32'h000000DB}, // R12 all three
    {4'd12, 6'b011000, 32'hF0000010, 32'h0,        32'h000000DB, 32'h100000F3}, // R12 ret vs wr
    {4'd3,  6'b001000, 32'h00000010, 32'h0,        32'h00000010, 32'h00000000}, // R3 to USR
    {4'd4,  6'b001000, 32'hF00000DF, 32'h0,        32'hF0000010, 32'h00000000}, // R4 user filter
    {4'd9,  6'b001100, 32'hFFFFFFFF, 32'h0,        32'hF0000010, 32'h00000000}, // R9 user saved
    {4'd11, 6'b010000, 32'h0,        32'h0,        32'hF0000010, 32'h00000000}, // R11 user ret
    {4'd5,  6'b001001, 32'h6ABCDEF0, 32'h0,        32'h60000010, 32'h00000000}, // R5 user flags
    {4'd10, 6'b100000, 32'h0,        32'h00000093, 32'h00000093, 32'h60000010}, // R10 enter SVC
    {4'd10, 6'b100000, 32'h0,        32'h0000001F, 32'h0000001F, 32'h00000000}, // R10 enter SYS
    {4'd11, 6'b010000, 32'h0,        32'h0,        32'h0000001F, 32'h00000000}, // R11 SYS ret
    {4'd2,  6'b100000, 32'h0,        32'h0FFFFFD1, 32'h000000D1, 32'h0000001F}  // R2 reserved
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_en = 1'b0; ret_en = 1'b0; wr_en = 1'b0; wr_saved = 1'b0;
    wr_kind = 2'd0; wr_data = '0; exc_psr = '0;
  endtask

  // Check live word and both read selections.
  task automatic observe(input int req, input logic [31:0] e_live,
                         input logic [31:0] e_sav);
    check(req, "live word", cur_psr, e_live);
    rd_sel_saved = 1'b0; #0.5;
    check(8, "read live", rd_data, e_live);
    rd_sel_saved = 1'b1; #0.5;
    check(req, "read saved", rd_data, e_sav);
    rd_sel_saved = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #0.5;
    observe(1, 32'h000000D3, 32'h0); // R1 reset state

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {exc_en, ret_en, wr_en, wr_saved, wr_kind} = VEC[v][133:128];
      wr_data = VEC[v][127:96];
      exc_psr = VEC[v][95:64];
      @(posedge clk);
      #0.5;
      idle_inputs();
      observe(int'(VEC[v][137:134]), VEC[v][63:32], VEC[v][31:0]);
    end

    // R1: reset mid-run clears saved slots that hold data (SVC, FIQ).
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #0.5;
    observe(1, 32'h000000D3, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'd0; wr_data = 32'h000000D1;
    @(posedge clk);
    #0.5;
    idle_inputs();
    observe(1, 32'h000000D1, 32'h0); // R1 FIQ slot cleared

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule